// File: doc/BRIEF.md
# Four-Pin I/O Port with Edge Interrupts

This block is a small general-purpose I/O port of four pins, placed on a simple register bus. Software writes an 8-bit mode register that gives each pin a 2-bit field. The field makes the pin either a push-pull output, or an input that flags a falling edge, a rising edge or both. A pull-up enable register and an output data register complete the set of registers. Every pin's pull-up can be enabled on its own, but only while the pin is an input.

Each input passes through a two-flop synchronizer. An edge detector then compares the current synchronized sample with the previous one. An edge of the selected kind sets that pin's pending flag. Software clears a flag by writing 1 to its bit. The four flags share one interrupt request line. A vector index beside that line names the lowest-numbered pending pin, so that an interrupt controller outside this block can dispatch each pin to its own handler.

Top module: `gpio4_port`

## Requirements
- R1: After reset, the mode, pull-up, data and pending registers all read 0. Every pin is therefore an input that flags falling edges, with pad_oe=0, pad_pu=0 and irq=0.
- R2: The register map is as follows.
  - Address 0 is the mode register: bits 2n+1:2n select the mode of pin n.
  - Address 1 is the pull-up register: bit n enables the pull-up of pin n, and bits 7:4 read 0.
  - Address 2 reads the data bits in 3:0 and the synchronized pin levels in 7:4. Only bits 3:0 are writable.
  - Address 3 reads the pending flags in bits 3:0, and bits 7:4 read 0.
- R3: Mode 2'b10 makes a pin a push-pull output. pad_oe=1, pad_out equals its data bit, and pad_pu=0 whatever its pull-up bit holds.
- R4: In any input mode (2'b00, 2'b01, 2'b11), pad_oe=0 and pad_pu equals the pin's pull-up bit.
- R5: In mode 2'b00, a falling pin level sets the pin's pending flag, and a rising level does not.
- R6: In mode 2'b11, a rising pin level sets the pending flag, and a falling level does not.
- R7: In mode 2'b01, both rising and falling levels set the pending flag.
- R8: A pad change made between clock edges shows as a pending flag after the third rising clock edge, and not yet after the second.
- R9: Writing 1 to bit n at address 3 clears pending flag n. Writing 0 leaves a flag unchanged.
- R10: If an edge is detected in the same cycle as the clear of its flag, the flag stays set.
- R11: A pin in output mode never sets its pending flag, whatever its pad input does.
- R12: irq is 1 exactly when any flag is pending. irq_vec gives the lowest-numbered pending pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write enable |
| bus_rdata | output | 8 | Read data, combinational from bus_addr |
| pad_in | input | 4 | Pin levels from the pads |
| pad_out | output | 4 | Output value to the pads |
| pad_oe | output | 4 | Output enable per pin |
| pad_pu | output | 4 | Pull-up enable per pin |
| irq | output | 1 | Combined interrupt request |
| irq_vec | output | 2 | Lowest pending pin index |

## Verification
Each of the four modes is tried with a rising and a falling pin transition on a rotating pin. These eight cases separate the falling, rising and both-edge encodings from one another, and from the output mode that flags nothing. Directed sequences then use a single toggle with samples after the second and third clock edges to pin down the synchronizer depth. A clear write that lands on the cycle of a detected edge shows whether the set takes priority. Simultaneous edges on two pins, cleared one at a time, show that the vector index follows the lowest pending pin, not the order in which the flags were set.

// File: rtl/gpio4_pkg.sv
package gpio4_pkg;

  typedef enum logic [1:0] {
    MODE_IN_FALL = 2'b00,
    MODE_IN_BOTH = 2'b01,
    MODE_OUT     = 2'b10,
    MODE_IN_RISE = 2'b11
  } pin_mode_e;

  localparam int REG_MODE = 0;
  localparam int REG_PULL = 1;
  localparam int REG_DATA = 2;
  localparam int REG_PEND = 3;

  function automatic logic mode_is_output(input logic [1:0] m);
    return m == MODE_OUT;
  endfunction

  function automatic logic edge_hit(input logic [1:0] m, input logic prev, input logic cur);
    logic rise;
    logic fall;
    rise = cur & ~prev;
    fall = prev & ~cur;
    case (m)
      MODE_IN_FALL: return fall;
      MODE_IN_BOTH: return rise | fall;
      MODE_IN_RISE: return rise;
      default:      return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/gpio4_regs.sv
module gpio4_regs #(
  parameter int NPINS = 4,
  parameter int DW    = 8,
  parameter int AW    = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [AW-1:0]      bus_addr,
  input  logic [DW-1:0]      bus_wdata,
  input  logic               bus_we,
  output logic [2*NPINS-1:0] mode_q,
  output logic [NPINS-1:0]   pull_q,
  output logic [NPINS-1:0]   data_q,
  output logic [NPINS-1:0]   clr_mask
);
  import gpio4_pkg::*;

  localparam int MW = 2 * NPINS;

  logic wr_mode, wr_pull, wr_data, wr_pend;

  assign wr_mode = bus_we && (bus_addr == AW'(REG_MODE));
  assign wr_pull = bus_we && (bus_addr == AW'(REG_PULL));
  assign wr_data = bus_we && (bus_addr == AW'(REG_DATA));
  assign wr_pend = bus_we && (bus_addr == AW'(REG_PEND));

  assign clr_mask = wr_pend ? bus_wdata[NPINS-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      pull_q <= '0;
      data_q <= '0;
    end else begin
      if (wr_mode) mode_q <= bus_wdata[MW-1:0];
      if (wr_pull) pull_q <= bus_wdata[NPINS-1:0];
      if (wr_data) data_q <= bus_wdata[NPINS-1:0];
    end
  end

endmodule

// File: rtl/gpio4_sync.sv
module gpio4_sync #(
  parameter int NPINS  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pad_in,
  output logic [NPINS-1:0] level
);

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    logic [STAGES-1:0] sr;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sr <= '0;
      else        sr <= {sr[STAGES-2:0], pad_in[i]};
    end
    assign level[i] = sr[STAGES-1];
  end

endmodule

// File: rtl/gpio4_edge.sv
module gpio4_edge #(
  parameter int NPINS = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [2*NPINS-1:0] mode,
  input  logic [NPINS-1:0]   level,
  input  logic [NPINS-1:0]   clr_mask,
  output logic [NPINS-1:0]   hit,
  output logic [NPINS-1:0]   pend
);
  import gpio4_pkg::*;

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    logic prev;
    logic [1:0] m;
    assign m      = mode[2*i +: 2];
    assign hit[i] = edge_hit(m, prev, level[i]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        prev    <= 1'b0;
        pend[i] <= 1'b0;
      end else begin
        prev    <= level[i];
        pend[i] <= (pend[i] & ~clr_mask[i]) | hit[i];
      end
    end
  end

endmodule

// File: rtl/gpio4_irq_sel.sv
module gpio4_irq_sel #(
  parameter int NPINS = 4,
  localparam int VW   = (NPINS > 1) ? $clog2(NPINS) : 1
) (
  input  logic [NPINS-1:0] pend,
  output logic             irq,
  output logic [VW-1:0]    irq_vec
);

  function automatic logic [VW-1:0] lowest_set(input logic [NPINS-1:0] v);
    logic [VW-1:0] idx;
    idx = '0;
    for (int k = NPINS - 1; k >= 0; k--) begin
      if (v[k]) idx = VW'(k);
    end
    return idx;
  endfunction

  assign irq     = |pend;
  assign irq_vec = lowest_set(pend);

endmodule

// File: rtl/gpio4_port.sv
module gpio4_port #(
  parameter int NPINS  = 4,
  parameter int DW     = 8,
  parameter int AW     = 2,
  parameter int STAGES = 2,
  localparam int VW    = (NPINS > 1) ? $clog2(NPINS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    bus_addr,
  input  logic [DW-1:0]    bus_wdata,
  input  logic             bus_we,
  output logic [DW-1:0]    bus_rdata,
  input  logic [NPINS-1:0] pad_in,
  output logic [NPINS-1:0] pad_out,
  output logic [NPINS-1:0] pad_oe,
  output logic [NPINS-1:0] pad_pu,
  output logic             irq,
  output logic [VW-1:0]    irq_vec
);
  import gpio4_pkg::*;

  logic [2*NPINS-1:0] mode_q;
  logic [NPINS-1:0]   pull_q, data_q, clr_mask, level, hit, pend;

  gpio4_regs #(.NPINS(NPINS), .DW(DW), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .mode_q(mode_q), .pull_q(pull_q), .data_q(data_q),
    .clr_mask(clr_mask)
  );

  gpio4_sync #(.NPINS(NPINS), .STAGES(STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pad_in(pad_in), .level(level)
  );

  gpio4_edge #(.NPINS(NPINS)) u_edge (
    .clk(clk), .rst_n(rst_n), .mode(mode_q), .level(level),
    .clr_mask(clr_mask), .hit(hit), .pend(pend)
  );

  gpio4_irq_sel #(.NPINS(NPINS)) u_sel (
    .pend(pend), .irq(irq), .irq_vec(irq_vec)
  );

  for (genvar i = 0; i < NPINS; i++) begin : g_pad
    logic is_out;
    assign is_out     = mode_is_output(mode_q[2*i +: 2]);
    assign pad_oe[i]  = is_out;
    assign pad_out[i] = is_out & data_q[i];
    assign pad_pu[i]  = ~is_out & pull_q[i];
  end

  always_comb begin
    case (bus_addr)
      AW'(REG_MODE): bus_rdata = DW'(mode_q);
      AW'(REG_PULL): bus_rdata = DW'(pull_q);
      AW'(REG_DATA): bus_rdata = DW'({level, data_q});
      AW'(REG_PEND): bus_rdata = DW'(pend);
      default:       bus_rdata = '0;
    endcase
  end

endmodule

// File: rtl/gpio4_port_chk.sv
module gpio4_port_chk #(
  parameter int NPINS = 4,
  parameter int VW    = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic [2*NPINS-1:0] mode_q,
  input logic [NPINS-1:0]   hit,
  input logic [NPINS-1:0]   pend,
  input logic [NPINS-1:0]   clr_mask,
  input logic [NPINS-1:0]   pad_oe,
  input logic [NPINS-1:0]   pad_pu,
  input logic               irq,
  input logic [VW-1:0]      irq_vec
);

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    // R10
    hit_sets_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hit[i] |=> pend[i]);
    // R9
    clear_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_mask[i] && !hit[i]) |=> !pend[i]);
    // R11
    out_no_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q[2*i +: 2] == 2'b10 && !pend[i]) |=> !pend[i]);
    // R3
    pu_off_when_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pad_pu[i] |-> !pad_oe[i]);
  end

  // R12
  irq_any_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend != '0) |-> irq);
  // R12
  vec_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (pend[irq_vec] && ((pend & ~({NPINS{1'b1}} << irq_vec)) == '0)));

endmodule

bind gpio4_port gpio4_port_chk #(.NPINS(NPINS), .VW(VW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_q(mode_q), .hit(hit), .pend(pend),
  .clr_mask(clr_mask), .pad_oe(pad_oe), .pad_pu(pad_pu), .irq(irq),
  .irq_vec(irq_vec)
);

// File: tb/test_gpio4_port.sv
module test_gpio4_port;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic       bus_we = 1'b0;
  logic [7:0] bus_rdata;
  logic [3:0] pad_in = '0;
  logic [3:0] pad_out, pad_oe, pad_pu;
  logic       irq;
  logic [1:0] irq_vec;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  gpio4_port i_gpio4_port (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu), .irq(irq),
    .irq_vec(irq_vec)
  );

  // {mode[1:0], level before, level after, flag expected}
  localparam logic [4:0] VECS [0:7] = '{
    5'b00_10_1, 5'b00_01_0,
    5'b01_01_1, 5'b01_10_1,
    5'b11_01_1, 5'b11_10_0,
    5'b10_01_0, 5'b10_10_0
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    bus_addr = a;
    #1;
    v = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    idle(3);
    rst_n = 1'b1;
    idle(1);

    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v);
      check("R1 reg after reset", v, 8'h00);
    end
    check("R1 pad_oe", pad_oe, 4'h0);
    check("R1 pad_pu", pad_pu, 4'h0);
    check("R1 irq", irq, 1'b0);

    // Table walk: R5 R6 R7 R11
    for (int k = 0; k < 8; k++) begin
      int p;
      logic [1:0] m;
      p = k % 4;
      m = VECS[k][4:3];
      pad_in = '0;
      wr(2'd0, 8'(m) << (2 * p));
      pad_in[p] = VECS[k][2];
      idle(5);
      wr(2'd3, 8'h0F);
      pad_in[p] = VECS[k][1];
      idle(5);
      rd(2'd3, v);
      check($sformatf("R5/R6/R7/R11 table row %0d", k), v, 8'(VECS[k][0]) << p);
    end
    pad_in = '0;
    idle(5);

    // R2 register map
    wr(2'd0, 8'hA5);
    rd(2'd0, v); check("R2 mode readback", v, 8'hA5);
    wr(2'd0, 8'h00);
    wr(2'd1, 8'hFF);
    rd(2'd1, v); check("R2 pull-up upper bits zero", v, 8'h0F);
    wr(2'd2, 8'hFC);
    pad_in = 4'b0110;
    idle(3);
    rd(2'd2, v); check("R2 data and levels", v, 8'h6C);
    pad_in = '0;
    idle(5);
    wr(2'd3, 8'h0F);

    // R4 input mode pads
    check("R4 oe in input", pad_oe, 4'h0);
    check("R4 pu follows reg", pad_pu, 4'hF);
    wr(2'd1, 8'h05);
    check("R4 pu partial", pad_pu, 4'h5);

    // R3 output mode pads
    wr(2'd1, 8'h0F);
    wr(2'd0, 8'hAA);
    check("R3 oe", pad_oe, 4'hF);
    check("R3 out follows data", pad_out, 4'hC);
    check("R3 pu forced off", pad_pu, 4'h0);
    wr(2'd2, 8'h03);
    check("R3 out new data", pad_out, 4'h3);

    // R11 toggling in output mode
    pad_in = 4'hF; idle(5);
    pad_in = 4'h0; idle(5);
    rd(2'd3, v); check("R11 no flag in output mode", v, 8'h00);

    // R8 latency, pin 0 both edges
    wr(2'd0, 8'h01);
    wr(2'd3, 8'h0F);
    pad_in[0] = 1'b1;
    idle(2);
    rd(2'd3, v); check("R8 not after second edge", v, 8'h00);
    idle(1);
    rd(2'd3, v); check("R8 set after third edge", v, 8'h01);

    // R9 clear
    wr(2'd3, 8'h00);
    rd(2'd3, v); check("R9 write 0 keeps", v, 8'h01);
    wr(2'd3, 8'h01);
    rd(2'd3, v); check("R9 write 1 clears", v, 8'h00);

    // R10 edge beats clear
    pad_in[0] = 1'b0;
    idle(5);
    rd(2'd3, v); check("R10 setup flag", v, 8'h01);
    pad_in[0] = 1'b1;
    idle(2);
    bus_addr = 2'd3; bus_wdata = 8'h01; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
    rd(2'd3, v); check("R10 edge wins over clear", v, 8'h01);
    wr(2'd3, 8'h01);
    rd(2'd3, v); check("R10 later clear works", v, 8'h00);

    // R12 priority
    wr(2'd0, 8'h55);
    idle(3);
    wr(2'd3, 8'h0F);
    check("R12 idle irq", irq, 1'b0);
    pad_in = pad_in ^ 4'b1010;
    idle(5);
    check("R12 irq", irq, 1'b1);
    check("R12 vec lowest of 1,3", irq_vec, 2'd1);
    wr(2'd3, 8'h02);
    check("R12 vec after clear", irq_vec, 2'd3);
    pad_in = pad_in ^ 4'b0100;
    idle(5);
    check("R12 vec 2 below 3", irq_vec, 2'd2);
    wr(2'd3, 8'h0C);
    check("R12 irq drops", irq, 1'b0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule